// File: doc/BRIEF.md
# Vector Message Dispatcher

This block turns per-vector interrupt requests into message writes. For each accepted request it reads the vector's table entry (64-bit address, 32-bit data, per-vector mask bit) and the vector's pending bit from external storage. It then does one of three things. It drops the request. It records the request as pending by issuing a set command to the pending array. Or it launches one address/data message on a valid/ready output. The decision depends on the global enable, the function-wide mask and the vector's own mask.

A deferred message is delivered in two cases. The first is a notice from the table register file that one vector's mask bit went from 1 to 0. The second is a configuration write that clears the function-wide mask, which starts a walk over every vector in ascending order. The block also holds the message-control register and the two locator registers that tell software where the table and the pending array live.

All data-carrying interfaces use valid/ready. A transfer happens on a rising clock edge where both are high. The message output raises `msg_valid` the cycle after the decision and holds address and data unchanged until `msg_ready` is seen. `req_ready` and `unm_ready` fall while a message waits for its handshake, during a walk, while a walk is armed, and for one cycle after a pending-array command. Upstream sources therefore hold their request until the block is free. `unm_valid` has priority over `req_valid` when both are presented.

Top module: `vecmsg_dispatch`

## Requirements
- R1: After reset, `cfg_ctrl` reads enable (bit 15) = 0, function mask (bit 14) = 1, bits 13:11 = 0 and bits 10:0 = NVEC-1. The locators read their reset parameters, and `msg_valid` and `busy` are low.
- R2: A write with `cfg_wr_sel` = 0 changes only bits 15 and 14 of `cfg_ctrl`. Bits 13:0 keep their configured values.
- R3: Writes with `cfg_wr_sel` = 1 (table locator) or 2 (pending locator) store bits 31:3 as the offset. Bits 2:0, the region indicator, are updated only when the written value is 5 or less; otherwise the old indicator is kept.
- R4: A request accepted while the enable is 0 produces no message and no pending-set command.
- R5: A request accepted while enabled, for a vector that is masked by the function mask or by its own mask, issues one `pend_set` for that vector and no message.
- R6: A request accepted while enabled and fully unmasked launches one message with the vector's table address and data. `msg_valid` rises in the cycle after acceptance and holds with stable contents until `msg_ready`.
- R7: A request or unmask notice with a vector index of NVEC or more is ignored.
- R8: An unmask notice for a vector whose pending bit is set, while enabled and not function-masked, launches that vector's message and issues `pend_clr`. Without a pending bit it does nothing.
- R9: Clearing the function mask while enabled walks vectors 0 to NVEC-1 in ascending order, one per cycle, stalling on each message handshake. Each individually unmasked pending vector is delivered and cleared; masked pending vectors stay pending.
- R10: `req_ready` and `unm_ready` are low whenever `busy` is high.
- R11: `busy` is high from the edge of the mask-clearing write until the walk ends, and while a message awaits `msg_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | 0 control, 1 table locator, 2 pending locator, 3 none |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_ctrl | output | 16 | Message-control register |
| cfg_tbl_loc | output | 32 | Table locator register |
| cfg_pend_loc | output | 32 | Pending-array locator register |
| req_valid | input | 1 | Interrupt request valid |
| req_ready | output | 1 | Interrupt request accepted |
| req_vec | input | 11 | Requested vector index |
| unm_valid | input | 1 | Per-vector unmask notice valid |
| unm_ready | output | 1 | Unmask notice accepted |
| unm_vec | input | 11 | Vector whose mask was cleared |
| ent_vec | output | 11 | Vector index looked up in table and pending array |
| ent_addr | input | 64 | Message address of `ent_vec` |
| ent_data | input | 32 | Message data of `ent_vec` |
| ent_mask | input | 1 | Per-vector mask of `ent_vec` |
| ent_pend | input | 1 | Pending bit of `ent_vec` |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Downstream accepts message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| pend_set | output | 1 | Set pending bit of `pend_vec` |
| pend_clr | output | 1 | Clear pending bit of `pend_vec` |
| pend_vec | output | 11 | Vector for the pending command |
| busy | output | 1 | Walk armed or running, or message outstanding |

## Verification
A sequencer stuck in a non-idle state keeps `busy` high and `req_ready` low, which stalls the next request within one cycle. A wrong walk index shows up as the wrong message data in the delivery log, or as a pending bit that stays set after the walk. A wrong mask decision is seen at the edge after acceptance: either a `pend_set` appears where a message was due, or the reverse. A message register that changes during back-pressure is seen while `msg_ready` is held low.

// File: rtl/vecmsg_pkg.sv
package vecmsg_pkg;
  localparam int MAX_VEC = 2048;
  localparam int VEC_W = $clog2(MAX_VEC);
  localparam int CTRL_EN_BIT = 15;
  localparam int CTRL_FM_BIT = 14;
  localparam int SIZE_W = 11;

  typedef enum logic [1:0] {
    CFG_CTRL = 2'd0,
    CFG_TBL  = 2'd1,
    CFG_PEND = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_SCAN,
    ST_SCAN_SEND
  } seq_state_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;
endpackage

// File: rtl/vecmsg_cfg_regs.sv
module vecmsg_cfg_regs
  import vecmsg_pkg::*;
#(
  parameter int NVEC = 16,
  parameter logic [31:0] TBL_LOC_INIT = 32'h0000_0000,
  parameter logic [31:0] PEND_LOC_INIT = 32'h0000_0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [15:0] ctrl,
  output logic [31:0] tbl_loc,
  output logic [31:0] pend_loc,
  output logic        en,
  output logic        fmask,
  output logic        scan_start
);
  localparam logic [SIZE_W-1:0] SIZE_FIELD = SIZE_W'(NVEC - 1);
  localparam logic [2:0] BIR_MAX = 3'd5;

  logic        en_q, fm_q;
  logic [31:0] tbl_q, pend_q;

  function automatic logic [31:0] upd_loc(input logic [31:0] old_v, input logic [31:0] new_v);
    logic [2:0] bir;
    bir = (new_v[2:0] <= BIR_MAX) ? new_v[2:0] : old_v[2:0];
    return {new_v[31:3], bir};
  endfunction

  logic wr_ctrl;
  assign wr_ctrl = wr_en && (wr_sel == CFG_CTRL);
  // Function mask falling edge caused by this write.
  assign scan_start = wr_ctrl && fm_q && !wr_data[CTRL_FM_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fm_q   <= 1'b1;
      tbl_q  <= TBL_LOC_INIT;
      pend_q <= PEND_LOC_INIT;
    end else if (wr_en) begin
      case (wr_sel)
        CFG_CTRL: begin
          en_q <= wr_data[CTRL_EN_BIT];
          fm_q <= wr_data[CTRL_FM_BIT];
        end
        CFG_TBL:  tbl_q  <= upd_loc(tbl_q, wr_data);
        CFG_PEND: pend_q <= upd_loc(pend_q, wr_data);
        default: ;
      endcase
    end
  end

  assign en       = en_q;
  assign fmask    = fm_q;
  assign ctrl     = {en_q, fm_q, 3'b000, SIZE_FIELD};
  assign tbl_loc  = tbl_q;
  assign pend_loc = pend_q;

  assert_bir_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == CFG_TBL && wr_data[2:0] > BIR_MAX) |=> (tbl_q[2:0] == $past(tbl_q[2:0])));
endmodule

// File: rtl/vecmsg_seq.sv
module vecmsg_seq
  import vecmsg_pkg::*;
#(
  parameter int NVEC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fmask,
  input  logic             scan_start,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  output logic             req_ready,
  input  logic             unm_valid,
  input  logic [VEC_W-1:0] unm_vec,
  output logic             unm_ready,
  output logic [VEC_W-1:0] rd_vec,
  input  logic             ent_mask,
  input  logic             ent_pend,
  input  logic             msg_done,
  output logic             load,
  output logic             pend_set,
  output logic             pend_clr,
  output logic [VEC_W-1:0] pend_vec,
  output logic             busy
);
  localparam logic [VEC_W:0]   NVEC_L = (VEC_W + 1)'(NVEC);
  localparam logic [VEC_W-1:0] LAST   = VEC_W'(NVEC - 1);

  seq_state_e       state;
  logic             arm_q, set_q, clr_q;
  logic [VEC_W-1:0] idx_q, pvec_q;

  function automatic logic in_range(input logic [VEC_W-1:0] v);
    return {1'b0, v} < NVEC_L;
  endfunction

  logic idle_ok, scanning;
  logic req_go, req_pend, req_send, unm_send, scan_hit;

  assign scanning  = (state == ST_SCAN) || (state == ST_SCAN_SEND);
  // A pending command must land in the array before the next lookup.
  assign idle_ok   = (state == ST_IDLE) && !arm_q && !set_q && !clr_q;
  assign unm_ready = idle_ok;
  assign req_ready = idle_ok && !unm_valid;

  always_comb begin
    if (scanning)       rd_vec = idx_q;
    else if (unm_valid) rd_vec = unm_vec;
    else                rd_vec = req_vec;
  end

  assign req_go   = req_valid && req_ready && in_range(req_vec) && en;
  assign req_pend = req_go && (fmask || ent_mask);
  assign req_send = req_go && !fmask && !ent_mask;
  assign unm_send = unm_valid && unm_ready && in_range(unm_vec) && en && !fmask
                    && !ent_mask && ent_pend;
  assign scan_hit = (state == ST_SCAN) && en && !fmask && !ent_mask && ent_pend;
  assign load     = req_send || unm_send || scan_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      arm_q  <= 1'b0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
      idx_q  <= '0;
      pvec_q <= '0;
    end else begin
      set_q <= req_pend;
      clr_q <= unm_send || scan_hit;
      if (req_pend || unm_send || scan_hit) pvec_q <= rd_vec;
      arm_q <= scan_start || (arm_q && state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (arm_q) begin
            state <= ST_SCAN;
            idx_q <= '0;
          end else if (load) begin
            state <= ST_SEND;
          end
        end
        ST_SEND: if (msg_done) state <= ST_IDLE;
        ST_SCAN: begin
          if (scan_hit)            state <= ST_SCAN_SEND;
          else if (idx_q == LAST)  state <= ST_IDLE;
          else                     idx_q <= idx_q + 1'b1;
        end
        ST_SCAN_SEND: begin
          if (msg_done) begin
            if (idx_q == LAST) begin
              state <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              state <= ST_SCAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pend_set = set_q;
  assign pend_clr = clr_q;
  assign pend_vec = pvec_q;
  assign busy     = (state != ST_IDLE) || arm_q;

  assert_set_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |-> $past(en));
  assert_set_clr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_set && pend_clr));
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || unm_ready) |-> !busy);
  assert_scan_ascends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN && $past(state) == ST_SCAN) |-> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/vecmsg_msg_out.sv
module vecmsg_msg_out
  import vecmsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  msg_t msg_in,
  input  logic ready,
  output logic valid,
  output msg_t msg,
  output logic done
);
  logic valid_q;
  msg_t msg_q;

  assign done = valid_q && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      msg_q   <= msg_in;
    end else if (done) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign msg   = msg_q;

  assert_msg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(msg_q)));
endmodule

// File: rtl/vecmsg_dispatch.sv
module vecmsg_dispatch
  import vecmsg_pkg::*;
#(
  parameter int NVEC = 16,
  parameter logic [31:0] TBL_LOC_INIT = 32'h0000_0000,
  parameter logic [31:0] PEND_LOC_INIT = 32'h0000_0800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [1:0]       cfg_wr_sel,
  input  logic [31:0]      cfg_wr_data,
  output logic [15:0]      cfg_ctrl,
  output logic [31:0]      cfg_tbl_loc,
  output logic [31:0]      cfg_pend_loc,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             unm_valid,
  output logic             unm_ready,
  input  logic [VEC_W-1:0] unm_vec,
  output logic [VEC_W-1:0] ent_vec,
  input  logic [63:0]      ent_addr,
  input  logic [31:0]      ent_data,
  input  logic             ent_mask,
  input  logic             ent_pend,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [63:0]      msg_addr,
  output logic [31:0]      msg_data,
  output logic             pend_set,
  output logic             pend_clr,
  output logic [VEC_W-1:0] pend_vec,
  output logic             busy
);
  logic en, fmask, scan_start, load, done;
  msg_t msg_in, msg_q;

  vecmsg_cfg_regs #(
    .NVEC(NVEC), .TBL_LOC_INIT(TBL_LOC_INIT), .PEND_LOC_INIT(PEND_LOC_INIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .ctrl(cfg_ctrl), .tbl_loc(cfg_tbl_loc),
    .pend_loc(cfg_pend_loc), .en(en), .fmask(fmask), .scan_start(scan_start)
  );

  vecmsg_seq #(.NVEC(NVEC)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .fmask(fmask), .scan_start(scan_start),
    .req_valid(req_valid), .req_vec(req_vec), .req_ready(req_ready),
    .unm_valid(unm_valid), .unm_vec(unm_vec), .unm_ready(unm_ready),
    .rd_vec(ent_vec), .ent_mask(ent_mask), .ent_pend(ent_pend),
    .msg_done(done), .load(load), .pend_set(pend_set), .pend_clr(pend_clr),
    .pend_vec(pend_vec), .busy(busy)
  );

  assign msg_in = '{addr: ent_addr, data: ent_data};

  vecmsg_msg_out u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .msg_in(msg_in), .ready(msg_ready),
    .valid(msg_valid), .msg(msg_q), .done(done)
  );

  assign msg_addr = msg_q.addr;
  assign msg_data = msg_q.data;

  assert_clr_with_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> msg_valid);
  assert_busy_while_msg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> busy);
endmodule

// File: tb/vecmsg_dispatch_tb_top.sv
module vecmsg_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int VW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          cfg_wr_en = 1'b0;
  logic [1:0]    cfg_wr_sel = 2'd3;
  logic [31:0]   cfg_wr_data = '0;
  logic [15:0]   cfg_ctrl;
  logic [31:0]   cfg_tbl_loc, cfg_pend_loc;
  logic          req_valid = 1'b0, req_ready;
  logic [VW-1:0] req_vec = '0;
  logic          unm_valid = 1'b0, unm_ready;
  logic [VW-1:0] unm_vec = '0;
  logic [VW-1:0] ent_vec;
  logic [63:0]   ent_addr;
  logic [31:0]   ent_data;
  logic          ent_mask, ent_pend;
  logic          msg_valid, msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;
  logic          pend_set, pend_clr, busy;
  logic [VW-1:0] pend_vec;

  // Models of the external table and pending array.
  logic [2047:0] mask_m = '0;
  logic [2047:0] pend_m = '0;
  logic          wipe = 1'b0;

  function automatic logic [63:0] addr_of(input logic [VW-1:0] v);
    return {16'hBEEF, 5'b0, v, 32'h0000_1000};
  endfunction
  function automatic logic [31:0] data_of(input logic [VW-1:0] v);
    return {16'hD0D0, 5'b0, v};
  endfunction

  assign ent_addr = addr_of(ent_vec);
  assign ent_data = data_of(ent_vec);
  assign ent_mask = mask_m[ent_vec];
  assign ent_pend = pend_m[ent_vec];

  vecmsg_dispatch #(.NVEC(NVEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .cfg_ctrl(cfg_ctrl), .cfg_tbl_loc(cfg_tbl_loc),
    .cfg_pend_loc(cfg_pend_loc), .req_valid(req_valid), .req_ready(req_ready),
    .req_vec(req_vec), .unm_valid(unm_valid), .unm_ready(unm_ready), .unm_vec(unm_vec),
    .ent_vec(ent_vec), .ent_addr(ent_addr), .ent_data(ent_data), .ent_mask(ent_mask),
    .ent_pend(ent_pend), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .pend_set(pend_set), .pend_clr(pend_clr),
    .pend_vec(pend_vec), .busy(busy)
  );

  int msg_cnt = 0, set_cnt = 0, clr_cnt = 0;
  logic [VW-1:0] log_v [16];
  logic [63:0]   last_addr = '0;
  logic [31:0]   last_data = '0;

  always @(posedge clk) begin
    if (wipe) pend_m <= '0;
    else begin
      if (pend_set) pend_m[pend_vec] <= 1'b1;
      if (pend_clr) pend_m[pend_vec] <= 1'b0;
    end
    if (pend_set) set_cnt <= set_cnt + 1;
    if (pend_clr) clr_cnt <= clr_cnt + 1;
    if (msg_valid && msg_ready) begin
      log_v[msg_cnt[3:0]] <= msg_data[VW-1:0];
      msg_cnt   <= msg_cnt + 1;
      last_addr <= msg_addr;
      last_data <= msg_data;
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_sel = 2'd3;
  endtask

  task automatic wait_idle();
    while (busy || !unm_ready) @(negedge clk);
  endtask

  task automatic send_req(input logic [VW-1:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vec = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_unm(input logic [VW-1:0] v);
    @(negedge clk);
    while (!unm_ready) @(negedge clk);
    unm_valid = 1'b1; unm_vec = v;
    @(negedge clk);
    unm_valid = 1'b0;
  endtask

  task automatic do_wipe();
    @(negedge clk); wipe = 1'b1;
    @(negedge clk); wipe = 1'b0;
  endtask

  // {enable, fmask, vector mask, expect(0 drop,1 pending,2 message), vector}
  localparam logic [15:0] VECS [10] = '{
    {1'b0, 1'b1, 1'b0, 2'd0, 11'd3},
    {1'b0, 1'b0, 1'b0, 2'd0, 11'd5},
    {1'b1, 1'b1, 1'b0, 2'd1, 11'd2},
    {1'b1, 1'b0, 1'b1, 2'd1, 11'd7},
    {1'b1, 1'b0, 1'b0, 2'd2, 11'd4},
    {1'b1, 1'b0, 1'b0, 2'd2, 11'd0},
    {1'b1, 1'b0, 1'b0, 2'd2, 11'd15},
    {1'b1, 1'b1, 1'b1, 2'd1, 11'd9},
    {1'b1, 1'b0, 1'b0, 2'd0, 11'd16},
    {1'b1, 1'b0, 1'b1, 2'd0, 11'd20}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_ctrl == 16'h400F, "R1 ctrl", 64'(cfg_ctrl), 64'h400F);
    check(cfg_tbl_loc == 32'h0 && cfg_pend_loc == 32'h800, "R1 locators",
          {cfg_tbl_loc, cfg_pend_loc}, {32'h0, 32'h800});
    check(!msg_valid && !busy, "R1 idle", {62'b0, msg_valid, busy}, 64'h0);

    // R2 only bits 15:14 writable
    cfg_write(2'd0, 32'h0000_3FFF);
    check(cfg_ctrl == 16'h000F, "R2 ctrl low bits", 64'(cfg_ctrl), 64'h000F);
    cfg_write(2'd0, 32'h0000_C000);
    check(cfg_ctrl == 16'hC00F, "R2 ctrl en+mask", 64'(cfg_ctrl), 64'hC00F);

    // R3 locator writes
    cfg_write(2'd1, 32'h1234_5675);
    check(cfg_tbl_loc == 32'h1234_5675, "R3 tbl loc", 64'(cfg_tbl_loc), 64'h12345675);
    cfg_write(2'd1, 32'hABCD_0017);
    check(cfg_tbl_loc == 32'hABCD_0015, "R3 tbl bad indicator", 64'(cfg_tbl_loc), 64'hABCD0015);
    cfg_write(2'd2, 32'h0000_1003);
    check(cfg_pend_loc == 32'h0000_1003, "R3 pend loc", 64'(cfg_pend_loc), 64'h1003);

    // Table-driven request decisions (R4 R5 R6 R7)
    foreach (VECS[i]) begin
      logic [15:0] e;
      int m0, s0;
      string tag;
      e = VECS[i];
      do_wipe();
      mask_m = '0;
      mask_m[e[10:0]] = e[13];
      cfg_write(2'd0, {16'h0, e[15], e[14], 14'h0});
      wait_idle();
      m0 = msg_cnt; s0 = set_cnt;
      send_req(e[10:0]);
      repeat (4) @(negedge clk);
      if (e[10:0] >= 11'(NVEC)) tag = "R7 out of range";
      else if (!e[15]) tag = "R4 disabled";
      else if (e[12:11] == 2'd1) tag = "R5 masked";
      else tag = "R6 delivered";
      case (e[12:11])
        2'd0: check(msg_cnt == m0 && set_cnt == s0, tag,
                    64'((msg_cnt - m0) * 16 + (set_cnt - s0)), 64'h0);
        2'd1: check(msg_cnt == m0 && set_cnt == s0 + 1 && pend_m[e[10:0]], tag,
                    64'((msg_cnt - m0) * 16 + (set_cnt - s0)), 64'h1);
        default: check(msg_cnt == m0 + 1 && set_cnt == s0 && last_data == data_of(e[10:0])
                       && last_addr == addr_of(e[10:0]), tag,
                       64'(last_data), 64'(data_of(e[10:0])));
      endcase
    end

    // R6 hold under back-pressure, R10/R11 while waiting
    do_wipe();
    mask_m = '0;
    cfg_write(2'd0, 32'h0000_8000);
    wait_idle();
    msg_ready = 1'b0;
    begin
      int m0;
      m0 = msg_cnt;
      send_req(11'd6);
      check(msg_valid && msg_data == data_of(11'd6), "R6 valid after accept",
            64'(msg_data), 64'(data_of(11'd6)));
      repeat (3) @(negedge clk);
      check(msg_valid && msg_addr == addr_of(11'd6) && msg_data == data_of(11'd6),
            "R6 held stable", msg_addr, addr_of(11'd6));
      check(busy && !req_ready && !unm_ready, "R10 R11 busy blocks requests",
            {61'b0, busy, req_ready, unm_ready}, 64'h4);
      msg_ready = 1'b1;
      @(negedge clk);
      check(!msg_valid && msg_cnt == m0 + 1, "R6 one handshake",
            64'(msg_cnt - m0), 64'h1);
    end

    // R8 single-vector unmask
    mask_m[10] = 1'b1;
    send_req(11'd10);
    repeat (2) @(negedge clk);
    check(pend_m[10], "R8 setup pending", 64'(pend_m[10]), 64'h1);
    mask_m[10] = 1'b0;
    begin
      int m0;
      m0 = msg_cnt;
      send_unm(11'd10);
      repeat (3) @(negedge clk);
      check(msg_cnt == m0 + 1 && last_data == data_of(11'd10) && !pend_m[10],
            "R8 unmask delivers", 64'(last_data), 64'(data_of(11'd10)));
      m0 = msg_cnt;
      send_unm(11'd11);
      repeat (3) @(negedge clk);
      check(msg_cnt == m0, "R8 unmask without pending", 64'(msg_cnt - m0), 64'h0);
      send_unm(11'd18);
      repeat (3) @(negedge clk);
      check(msg_cnt == m0, "R7 unmask out of range", 64'(msg_cnt - m0), 64'h0);
    end

    // R9 walk on function-mask release
    do_wipe();
    mask_m = '0;
    mask_m[3] = 1'b1;
    cfg_write(2'd0, 32'h0000_C000);
    wait_idle();
    send_req(11'd1);
    send_req(11'd3);
    send_req(11'd12);
    wait_idle();
    begin
      int m0;
      m0 = msg_cnt;
      check(msg_cnt == m0 && pend_m[1] && pend_m[3] && pend_m[12], "R9 setup pending",
            {61'b0, pend_m[1], pend_m[3], pend_m[12]}, 64'h7);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = 2'd0; cfg_wr_data = 32'h0000_8000;
      @(negedge clk);
      cfg_wr_en = 1'b0; cfg_wr_sel = 2'd3;
      check(busy && !req_ready, "R11 R10 busy at walk start",
            {62'b0, busy, req_ready}, 64'h2);
      wait_idle();
      check(msg_cnt == m0 + 2, "R9 walk message count", 64'(msg_cnt - m0), 64'h2);
      check(log_v[m0[3:0]] == 11'd1 && log_v[4'(m0 + 1)] == 11'd12, "R9 ascending order",
            {21'b0, log_v[m0[3:0]], 21'b0, log_v[4'(m0 + 1)]}, {32'd1, 32'd12});
      check(!pend_m[1] && pend_m[3] && !pend_m[12], "R9 pending after walk",
            {61'b0, pend_m[1], pend_m[3], pend_m[12]}, 64'h2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule